// File: doc/BRIEF.md
# Loopback Receive Frame Checker

This block sits at the end of a loopback path and takes back the serial bit stream that the transmitter sent. While idle it hunts the stream for a preamble followed by the start-of-frame delimiter. Once it has locked on, it packs each following group of eight bits into a byte and writes that byte straight into a receive FIFO. No buffer memory is involved. It keeps a running count of the received bytes and accumulates a CRC-32 over everything after the delimiter. It also compares the leading bytes of the frame against a configured station address.

When the frame ends, the block writes the 16-bit byte count into the FIFO behind the data and then updates a small receive status register. The CRC rules follow loopback conventions:
- A configuration bit enables the CRC check. While that bit is low, the check is skipped and a CRC error condition is assumed.
- The intact flag does not depend on the address comparison.
- The CRC error flag is raised only for frames whose destination address matched.

Top module: `lbrx_frame_check`

## Requirements
- R1: No byte reaches the FIFO before a delimiter has been recognised. The delimiter is the byte 0xD5, with bits assembled least significant bit first. It must be immediately preceded by at least one preamble pair, which is a 1 bit followed by a 0 bit in arrival order. With the default parameter, a stream such as 1,1 followed by 0xD5 is not a delimiter. A frame end seen while hunting writes nothing and leaves the status unchanged.
- R2: After the delimiter, data bits are assembled least significant bit first. Each completed byte appears on `fifo_wdata` with `fifo_we` high in the cycle after the clock edge that sampled its eighth bit.
- R3: `rx_byte_cnt` is cleared to 0 when a delimiter is recognised. It then rises by one for each completed byte.
- R4: `rx_eof` during a frame discards any partial byte. The block then writes the byte count on the next two cycles, low byte first (the cycle after the `rx_eof` edge) and then high byte.
- R5: The status outputs are loaded and `stat_upd` pulses for one cycle together with the high count byte. At all other times the status outputs hold their values.
- R6: With `cfg_crc_chk` = 1, a CRC error condition exists exactly when the CRC-32 residue over the data and FCS differs from 0xC704DD7B. That value is in MSB-first polynomial order. The CRC is reflected, starts from all ones, and takes each bit in arrival order.
- R7: With `cfg_crc_chk` = 0, the check is skipped and a CRC error condition is always assumed.
- R8: `stat_intact` is 1 exactly when there is no CRC error condition, whatever the address comparison gave.
- R9: `stat_crc_err` is 1 only when a CRC error condition exists and the address matched.
- R10: `stat_addr_hit` is 1 when the first six received bytes equal `cfg_station_addr`, byte i against bits [8i+7:8i]. A frame shorter than six bytes never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial data bit from the loopback path |
| rx_bit_vld | input | 1 | `rx_bit` carries a bit this cycle |
| rx_eof | input | 1 | End of the current frame (no bit is taken in this cycle) |
| cfg_crc_chk | input | 1 | 1: check the CRC, 0: skip the check and flag an error condition |
| cfg_station_addr | input | 48 | Station address; byte 0 is bits [7:0] |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| rx_byte_cnt | output | 16 | Bytes received since the last delimiter |
| stat_upd | output | 1 | One-cycle pulse when the status is loaded |
| stat_intact | output | 1 | Frame received intact |
| stat_crc_err | output | 1 | CRC error on an address-matched frame |
| stat_addr_hit | output | 1 | Destination address matched the station address |

## Verification
The block has three result times, each counted from the edge that samples the relevant input:
- A data byte and its updated count are visible one cycle after the edge that samples its eighth bit.
- The low count byte is visible one cycle after the edge that samples `rx_eof`.
- The high count byte, `stat_upd` and the new status are visible two cycles after that edge.

The bench drives one bit per cycle on the falling edge and checks `fifo_we` on the next falling edge. Every check therefore lands exactly on the cycle where the result is due. An early or late write fails a check rather than being absorbed. The expected status comes from how each frame was built (address kept or altered, FCS kept or corrupted, check enabled or not), never from the design.

// File: rtl/lbrx_pkg.sv
package lbrx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_DATA   = 2'd1,
    ST_CNT_HI = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic intact;
    logic crc_err;
    logic addr_hit;
  } rx_status_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;

  // one reflected CRC-32 step for a single arriving bit
  function automatic logic [31:0] crc_bit_step(input logic [31:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_REFL : 32'h0);
  endfunction

  // eight steps, least significant bit of the byte first
  function automatic logic [31:0] crc_byte_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = crc_bit_step(r, d[i]);
    return r;
  endfunction

  function automatic logic [31:0] bit_reverse32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // the residue is given in MSB-first polynomial order; the register is reflected
  function automatic logic residue_good(input logic [31:0] reg_val, input logic [31:0] residue_msb);
    return reg_val == bit_reverse32(residue_msb);
  endfunction

  // status rules for a looped-back frame
  function automatic rx_status_t judge_frame(input logic chk_en, input logic crc_ok,
                                             input logic hit);
    rx_status_t s;
    logic err_cond;
    err_cond   = chk_en ? !crc_ok : 1'b1;
    s.intact   = !err_cond;
    s.crc_err  = err_cond && hit;
    s.addr_hit = hit;
    return s;
  endfunction

endpackage

// File: rtl/lbrx_sfd_hunt.sv
module lbrx_sfd_hunt #(
  parameter int          PAIRS = 1,
  parameter logic [7:0]  SFD   = 8'hD5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clear,
  input  logic bit_vld,
  input  logic bit_in,
  output logic found
);
  localparam int W      = 2 * PAIRS + 8;
  localparam int FILL_W = $clog2(W + 1);
  // newest bit at the top; each pair arrives as 1 then 0
  localparam logic [W-1:0] PATTERN = {SFD, {PAIRS{2'b01}}};

  logic [W-1:0]      win_q;
  logic [W-1:0]      win_next;
  logic [FILL_W-1:0] fill_q;
  logic              shift;
  logic              full_enough;

  assign shift       = enable && bit_vld && !clear;
  assign win_next    = {bit_in, win_q[W-1:1]};
  assign full_enough = fill_q >= FILL_W'(W - 1);
  assign found       = shift && full_enough && (win_next == PATTERN);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || found || !enable) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift) begin
      win_q <= win_next;
      if (fill_q < FILL_W'(W)) fill_q <= fill_q + 1'b1;
    end
  end

  // R1: a delimiter is never reported before a full window has arrived
  assert_found_needs_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (fill_q >= FILL_W'(W - 1)));

endmodule

// File: rtl/lbrx_byte_pack.sv
module lbrx_byte_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       take,
  input  logic       bit_in,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic [7:0] sr_q;
  logic [2:0] nbit_q;

  assign byte_val  = {bit_in, sr_q[7:1]};
  assign byte_done = take && (nbit_q == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sr_q   <= '0;
      nbit_q <= '0;
    end else if (take) begin
      sr_q   <= byte_val;
      nbit_q <= nbit_q + 3'd1;
    end
  end

  // R2: a byte completes only on the eighth accepted bit
  assert_byte_on_eighth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (nbit_q == 3'd0));

endmodule

// File: rtl/lbrx_crc_acc.sv
module lbrx_crc_acc #(
  parameter logic [31:0] RESIDUE = 32'hC704DD7B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       crc_ok
);
  import lbrx_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc_q <= CRC_INIT;
    else if (byte_vld)   crc_q <= crc_byte_step(crc_q, byte_in);
  end

  assign crc_ok = residue_good(crc_q, RESIDUE);

  // R6: the accumulator only moves when a byte is committed
  assert_crc_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !clear) |=> $stable(crc_q));

endmodule

// File: rtl/lbrx_addr_filter.sv
module lbrx_addr_filter #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_in,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    hit
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);

  logic [IDX_W-1:0] idx_q;
  logic             run_q;
  logic             in_addr;
  logic [7:0]       want;

  assign in_addr = idx_q < IDX_W'(ADDR_BYTES);
  assign want    = in_addr ? station_addr[8*int'(idx_q) +: 8] : 8'h00;
  assign hit     = run_q && (idx_q == IDX_W'(ADDR_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      idx_q <= '0;
      run_q <= 1'b1;
    end else if (byte_vld && in_addr) begin
      idx_q <= idx_q + 1'b1;
      run_q <= run_q && (byte_in == want);
    end
  end

  // R10: once the address field is complete the comparison no longer changes
  assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && idx_q == IDX_W'(ADDR_BYTES)) |=> $stable(run_q));

endmodule

// File: rtl/lbrx_frame_check.sv
module lbrx_frame_check #(
  parameter int          PREAMBLE_PAIRS = 1,
  parameter logic [7:0]  SFD_BYTE       = 8'hD5,
  parameter int          ADDR_BYTES     = 6,
  parameter logic [31:0] CRC_RESIDUE    = 32'hC704DD7B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_bit,
  input  logic                    rx_bit_vld,
  input  logic                    rx_eof,
  input  logic                    cfg_crc_chk,
  input  logic [8*ADDR_BYTES-1:0] cfg_station_addr,
  output logic                    fifo_we,
  output logic [7:0]              fifo_wdata,
  output logic [15:0]             rx_byte_cnt,
  output logic                    stat_upd,
  output logic                    stat_intact,
  output logic                    stat_crc_err,
  output logic                    stat_addr_hit
);
  import lbrx_pkg::*;

  localparam int CNT_W = 16;

  rx_state_e   state_q;
  logic [CNT_W-1:0] cnt_q;
  logic        we_q;
  logic [7:0]  wdata_q;
  logic        upd_q;
  rx_status_t  stat_q;

  // named internal events
  logic        in_hunt;
  logic        in_data;
  logic        sfd_found;
  logic        bit_take;
  logic        byte_commit;
  logic [7:0]  byte_val;
  logic        crc_ok;
  logic        addr_hit;
  logic        hunt_clear;
  rx_status_t  verdict;

  assign in_hunt    = state_q == ST_HUNT;
  assign in_data    = state_q == ST_DATA;
  assign bit_take   = in_data && rx_bit_vld && !rx_eof;
  assign hunt_clear = rx_eof || !in_hunt;
  assign verdict    = judge_frame(cfg_crc_chk, crc_ok, addr_hit);

  lbrx_sfd_hunt #(.PAIRS(PREAMBLE_PAIRS), .SFD(SFD_BYTE)) u_hunt (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (in_hunt),
    .clear   (hunt_clear),
    .bit_vld (rx_bit_vld),
    .bit_in  (rx_bit),
    .found   (sfd_found)
  );

  lbrx_byte_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (sfd_found),
    .take      (bit_take),
    .bit_in    (rx_bit),
    .byte_done (byte_commit),
    .byte_val  (byte_val)
  );

  lbrx_crc_acc #(.RESIDUE(CRC_RESIDUE)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sfd_found),
    .byte_vld (byte_commit),
    .byte_in  (byte_val),
    .crc_ok   (crc_ok)
  );

  lbrx_addr_filter #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (sfd_found),
    .byte_vld     (byte_commit),
    .byte_in      (byte_val),
    .station_addr (cfg_station_addr),
    .hit          (addr_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      upd_q   <= 1'b0;
      stat_q  <= '0;
    end else begin
      we_q  <= 1'b0;
      upd_q <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (sfd_found) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end
        end
        ST_DATA: begin
          if (rx_eof) begin
            we_q    <= 1'b1;
            wdata_q <= cnt_q[7:0];
            state_q <= ST_CNT_HI;
          end else if (byte_commit) begin
            we_q    <= 1'b1;
            wdata_q <= byte_val;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_CNT_HI: begin
          we_q    <= 1'b1;
          wdata_q <= cnt_q[15:8];
          upd_q   <= 1'b1;
          stat_q  <= verdict;
          state_q <= ST_HUNT;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign fifo_we       = we_q;
  assign fifo_wdata    = wdata_q;
  assign rx_byte_cnt   = cnt_q;
  assign stat_upd      = upd_q;
  assign stat_intact   = stat_q.intact;
  assign stat_crc_err  = stat_q.crc_err;
  assign stat_addr_hit = stat_q.addr_hit;

  // R1: nothing is written for a cycle spent hunting
  assert_no_write_hunting_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_hunt |=> !fifo_we);

  // R3: each committed byte advances the count by exactly one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && byte_commit && !rx_eof) |=> (rx_byte_cnt == $past(rx_byte_cnt) + 16'd1));

  // R4: the high count byte follows the low one
  assert_count_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CNT_HI) |=> (fifo_we && fifo_wdata == $past(rx_byte_cnt[15:8])));

  // R5: status changes only on an update pulse
  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_upd |-> $stable({stat_intact, stat_crc_err, stat_addr_hit}));

  // R8: an intact frame never carries a CRC error
  assert_intact_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd |-> !(stat_intact && stat_crc_err));

  // R9: a CRC error is only reported for a matched address
  assert_crcerr_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd |-> (!stat_crc_err || stat_addr_hit));

endmodule

// File: tb/test_lbrx_frame_check.sv
module test_lbrx_frame_check;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_bit, rx_bit_vld, rx_eof, cfg_crc_chk;
  logic [47:0] cfg_station_addr;
  logic        fifo_we;
  logic [7:0]  fifo_wdata;
  logic [15:0] rx_byte_cnt;
  logic        stat_upd, stat_intact, stat_crc_err, stat_addr_hit;

  always #5 clk = ~clk;

  lbrx_frame_check i_lbrx_frame_check (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .rx_eof(rx_eof),
    .cfg_crc_chk(cfg_crc_chk), .cfg_station_addr(cfg_station_addr),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .rx_byte_cnt(rx_byte_cnt),
    .stat_upd(stat_upd), .stat_intact(stat_intact), .stat_crc_err(stat_crc_err),
    .stat_addr_hit(stat_addr_hit)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [2:0] last_stat = 3'b000;  // {intact, crc_err, hit}

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // inputs change on the falling edge; results of the edge in between are read on the next
  task automatic step(input bit v, input bit b, input bit e);
    rx_bit_vld = v; rx_bit = b; rx_eof = e;
    @(negedge clk);
  endtask

  // reference CRC, reflected, all-ones start, bits in arrival order
  function automatic logic [31:0] ref_crc(input byte unsigned q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[k]) begin
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ q[k][j]) c = (c >> 1) ^ 32'hEDB88320;
        else                c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic send_frame(input string tag, input int pairs, input bit dbl_one,
                            input byte unsigned q[$], input bit capture,
                            input logic [2:0] exp_stat);
    int n = q.size();
    for (int p = 0; p < pairs; p++) begin
      step(1, 1, 0); chk("R1", "we in preamble", fifo_we, 0);
      step(1, 0, 0); chk("R1", "we in preamble", fifo_we, 0);
    end
    if (dbl_one) begin
      step(1, 1, 0); step(1, 1, 0);
    end
    for (int j = 0; j < 8; j++) begin
      step(1, (8'hD5 >> j) & 1, 0);
      chk("R1", "we in delimiter", fifo_we, 0);
    end
    if (capture) chk("R3", "count after delimiter", rx_byte_cnt, 0);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) begin
        step(1, q[k][j], 0);
        if (capture && j == 7) begin
          chk("R2", "we on byte", fifo_we, 1);
          chk("R2", "byte value", fifo_wdata, q[k]);
          chk("R3", "count", rx_byte_cnt, k + 1);
        end else begin
          chk(capture ? "R2" : "R1", "we mid byte", fifo_we, 0);
        end
      end
    end
    step(0, 0, 1);
    if (capture) begin
      chk("R4", "we count lo", fifo_we, 1);
      chk("R4", "count lo", fifo_wdata, n & 8'hFF);
      chk("R5", "no early update", stat_upd, 0);
    end else begin
      chk("R1", "no write on stray eof", fifo_we, 0);
    end
    step(0, 0, 0);
    if (capture) begin
      chk("R4", "we count hi", fifo_we, 1);
      chk("R4", "count hi", fifo_wdata, (n >> 8) & 8'hFF);
      chk("R5", "update pulse", stat_upd, 1);
      chk(tag, "intact (R8)", stat_intact, exp_stat[2]);
      chk(tag, "crc err (R9)", stat_crc_err, exp_stat[1]);
      chk(tag, "addr hit (R10)", stat_addr_hit, exp_stat[0]);
      last_stat = exp_stat;
    end else begin
      chk("R1", "no write", fifo_we, 0);
      chk("R5", "no update", stat_upd, 0);
    end
    step(0, 0, 0);
    chk("R4", "write stops", fifo_we, 0);
    chk("R5", "pulse ends", stat_upd, 0);
    chk("R5", "status held", {stat_intact, stat_crc_err, stat_addr_hit}, last_stat);
    step(0, 0, 0);
  endtask

  // frame = address field, payload, FCS; status expected from construction
  task automatic run_case(input string tag, input int pairs, input bit addr_ok,
                          input int plen, input bit corrupt, input bit chk_on);
    byte unsigned q[$];
    logic [31:0] c;
    bit errc;
    cfg_crc_chk = chk_on;
    for (int i = 0; i < 6; i++) begin
      byte unsigned a = cfg_station_addr[8*i +: 8];
      if (!addr_ok && i == 3) a = a ^ 8'h40;
      q.push_back(a);
    end
    for (int i = 0; i < plen; i++) q.push_back(byte'((i * 37 + 11) & 8'hFF));
    c = ~ref_crc(q);
    for (int i = 0; i < 4; i++) q.push_back(c[8*i +: 8]);
    if (corrupt) q[q.size() - 4] = q[q.size() - 4] ^ 8'h01;
    errc = chk_on ? corrupt : 1'b1;
    send_frame(tag, pairs, 0, q, 1, {!errc, errc && addr_ok, addr_ok});
  endtask

  initial begin
    byte unsigned zq[$];
    byte unsigned sq[$];
    rst_n = 1'b0; rx_bit = 0; rx_bit_vld = 0; rx_eof = 0; cfg_crc_chk = 1;
    cfg_station_addr = 48'hB4_21_96_0F_C3_5A;
    repeat (3) @(negedge clk);
    chk("R5", "reset status", {stat_upd, stat_intact, stat_crc_err, stat_addr_hit}, 0);
    chk("R3", "reset count", rx_byte_cnt, 0);
    chk("R1", "reset we", fifo_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case("R6", 28, 1, 10, 0, 1);   // good frame, match
    run_case("R8", 1,  0, 10, 0, 1);   // good frame, mismatch, one pair
    run_case("R6", 4,  1, 20, 1, 1);   // bad FCS, match
    run_case("R9", 4,  0, 20, 1, 1);   // bad FCS, mismatch
    run_case("R7", 2,  1, 8,  0, 0);   // check skipped, match
    run_case("R7", 2,  0, 8,  0, 0);   // check skipped, mismatch
    run_case("R4", 28, 1, 260, 0, 1);  // count above 255

    // R10: four bytes only, equal to the address start -> no hit
    cfg_crc_chk = 1;
    for (int i = 0; i < 4; i++) sq.push_back(cfg_station_addr[8*i +: 8]);
    send_frame("R10", 3, 0, sq, 1, 3'b000);

    // R1: delimiter with no preamble pair, then 1,1 before it: both ignored
    for (int i = 0; i < 3; i++) zq.push_back(8'h00);
    send_frame("R1", 0, 0, zq, 0, 3'b000);
    send_frame("R1", 0, 1, zq, 0, 3'b000);

    // capture works again after the ignored attempts
    run_case("R6", 1, 1, 5, 0, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule